// File: doc/BRIEF.md
# Systolic Population Counter

This block counts how many bits are set in an N-bit input word. It takes a new word on every clock and returns the count a fixed number of cycles later. It has no stall path and no back-pressure. Callers put a word and a qualifier on the input. They get the count and a matching qualifier back after a latency that depends only on N.

The block does not use a tree of adders that grow wider at each level. It uses a regular triangular array instead. Input bit k is delayed through k skew registers, and on each clock it moves one row deeper while the unused part of the word narrows by one. Bit k then enters incrementer stage k. The incrementer column holds a running partial count in carry-save form, a sum word plus a carry word. Each stage adds one new bit with a single 3:2 compressor row, so the logic depth per stage is constant whatever N is. At the bottom of the column, a short pipelined prefix adder turns the carry-save pair into a plain binary count.

Top module: `popc_systolic`

## Requirements
- R1: When a result is marked valid, `out_count` equals the number of ones in the input word it belongs to, for every possible word.
- R2: A word is accepted on every cycle in which `in_valid` is high, including long back-to-back runs. Each accepted word produces exactly one valid result, in the order the words arrived.
- R3: A word sampled at a rising edge together with `in_valid` appears at the outputs right after the LAT-th rising edge, counting the sampling edge as the first. LAT = N + ceil(log2(CW)) + 2.
- R4: `out_count` is CW = ceil(log2(N+1)) bits wide and never exceeds N. An all-ones word yields N and an all-zeros word yields 0.
- R5: `out_valid` is high only in cycles that carry a result. The value of `in_data` in a cycle with `in_valid` low has no effect, and that cycle produces no valid output.
- R6: A low `rst_n` at a rising edge clears every in-flight qualifier. `out_valid` is low after that edge, and words accepted before the reset never appear. Data registers are not reset.
- R7: Inside the column, the carry-save partial count held at stage k never exceeds k+1 while that stage holds a valid word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | N | Word whose set bits are counted |
| out_valid | output | 1 | Qualifies `out_count` in this cycle |
| out_count | output | CW | Number of set bits in the matching input word |

## Verification
A wrong skew-register tap or a broken compressor bit in the column shows up as a wrong count. It appears exactly LAT cycles after the first word that sets the affected bit, so sweeping every word of a small configuration back to back exposes it within one latency. A fault in the qualifier chain shows up as a result that is missing, extra or shifted by a cycle. Idle gaps, a single isolated word and a reset in mid-flight are used to separate these fault types.

// File: rtl/popc_pkg.sv
// popc_pkg: shared sizing helpers for the systolic population counter.
// Assumes N >= 2, so the count is at least two bits wide.
package popc_pkg;

    // Width needed to hold a count from 0 to n.
    function automatic int popc_cw(input int n);
        return $clog2(n + 1);
    endfunction

    // Number of prefix levels needed to resolve a cw-bit carry-save pair.
    function automatic int popc_lvls(input int cw);
        return $clog2(cw);
    endfunction

endpackage

// File: rtl/popc_skew.sv
// popc_skew: triangular skew array. Row k holds bits k..N-1 of the word
// accepted k cycles ago, so tap[k] presents bit k exactly when incrementer
// stage k needs it. Assumes N >= 2. The rows carry data only and have no reset.
module popc_skew #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic [N-1:0] in_data,
    output logic [N-1:0] tap
);

    assign tap[0] = in_data[0];

    genvar k;
    generate
        for (k = 1; k < N; k++) begin : g_row
            logic [N-1-k:0] row_q;
            if (k == 1) begin : g_first
                // Purpose: first row takes every bit except bit 0 straight from the input.
                always_ff @(posedge clk) begin
                    row_q <= in_data[N-1:1];
                end
            end else begin : g_next
                // Purpose: each row drops the bit consumed above and moves the rest one row down.
                always_ff @(posedge clk) begin
                    row_q <= g_row[k-1].row_q[N-k:1];
                end
            end
            assign tap[k] = row_q[0];
        end
    endgenerate

endmodule

// File: rtl/popc_csa_cell.sv
// popc_csa_cell: one carry-save incrementer of the column. It adds a single
// bit to the partial count held as (sum + carry) with one 3:2 compressor row.
// Assumes that the true partial count after stage K fits in CW bits.
module popc_csa_cell #(
    parameter int CW = 6,
    parameter int K  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_in,
    input  logic [CW-1:0] s_in,
    input  logic [CW-1:0] c_in,
    input  logic          bit_in,
    output logic          v_q,
    output logic [CW-1:0] s_q,
    output logic [CW-1:0] c_q
);

    logic [CW-1:0] b_vec;
    logic [CW-1:0] maj;

    // Purpose: place the arriving bit at weight 1 and form the compressor carries.
    always_comb begin
        b_vec    = '0;
        b_vec[0] = bit_in;
        maj      = (s_in & c_in) | (s_in & b_vec) | (c_in & b_vec);
    end

    // Purpose: register the compressed pair (carry out of the top bit is always zero).
    always_ff @(posedge clk) begin
        s_q <= s_in ^ c_in ^ b_vec;
        c_q <= maj << 1;
    end

    // Purpose: qualifier follows the word; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // R7: a stage that has seen K+1 bits cannot hold more than K+1.
    assert_partial_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (({1'b0, s_q} + {1'b0, c_q}) <= (CW+1)'(K + 1)));

endmodule

// File: rtl/popc_resolve.sv
// popc_resolve: pipelined prefix adder that turns a carry-save pair into a
// binary value. One register level forms propagate/generate, LVLS levels merge
// them with doubling span, and a last register forms the sum. Latency LVLS+2.
// Assumes LVLS = ceil(log2(CW)) >= 1.
module popc_resolve #(
    parameter int CW   = 6,
    parameter int LVLS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v_in,
    input  logic [CW-1:0] s_in,
    input  logic [CW-1:0] c_in,
    output logic          v_out,
    output logic [CW-1:0] sum
);

    localparam int RES_LAT = LVLS + 2;

    logic [CW-1:0] g_q  [0:LVLS];
    logic [CW-1:0] x_q  [0:LVLS];
    logic [CW-1:0] p_q  [0:LVLS-1];
    logic          v_q  [0:LVLS];

    // Purpose: first level registers bit-wise propagate and generate.
    always_ff @(posedge clk) begin
        g_q[0] <= s_in & c_in;
        p_q[0] <= s_in ^ c_in;
        x_q[0] <= s_in ^ c_in;
    end

    // Purpose: qualifier for the first level.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q[0] <= 1'b0;
        else        v_q[0] <= v_in;
    end

    genvar l;
    generate
        for (l = 1; l <= LVLS; l++) begin : g_lvl
            localparam int SPAN = 1 << (l - 1);

            // Purpose: merge group generate over a span of SPAN bits; keep the half-sum.
            always_ff @(posedge clk) begin
                g_q[l] <= g_q[l-1] | (p_q[l-1] & (g_q[l-1] << SPAN));
                x_q[l] <= x_q[l-1];
            end

            if (l < LVLS) begin : g_prop
                // Purpose: merge group propagate for the following level.
                always_ff @(posedge clk) begin
                    p_q[l] <= p_q[l-1] & (p_q[l-1] << SPAN);
                end
            end

            // Purpose: qualifier for this prefix level.
            always_ff @(posedge clk) begin
                if (!rst_n) v_q[l] <= 1'b0;
                else        v_q[l] <= v_q[l-1];
            end
        end
    endgenerate

    // Purpose: final sum from half-sum and carries into each bit.
    always_ff @(posedge clk) begin
        sum <= x_q[LVLS] ^ (g_q[LVLS] << 1);
    end

    // Purpose: output qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_q[LVLS];
    end

    // R1: the resolved value equals the pair that entered RES_LAT cycles earlier.
    assert_resolve_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        v_out |-> (sum == CW'($past(s_in, RES_LAT) + $past(c_in, RES_LAT))));

endmodule

// File: rtl/popc_systolic.sv
// popc_systolic: top level of the systolic population counter. Skew array,
// column of N carry-save incrementers, then the pipelined resolver.
// Latency N + LVLS + 2 cycles, full throughput. Assumes N >= 2.
// Synchronous active-low reset clears the qualifiers only.
module popc_systolic
    import popc_pkg::*;
#(
    parameter  int N    = 32,
    localparam int CW   = popc_cw(N),
    localparam int LVLS = popc_lvls(CW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [N-1:0]  in_data,
    output logic          out_valid,
    output logic [CW-1:0] out_count
);

    logic [N-1:0]  tap;
    logic [CW-1:0] s_w [0:N];
    logic [CW-1:0] c_w [0:N];
    logic          v_w [0:N];

    popc_skew #(.N(N)) skew_i (
        .clk     (clk),
        .in_data (in_data),
        .tap     (tap)
    );

    assign s_w[0] = '0;
    assign c_w[0] = '0;
    assign v_w[0] = in_valid;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_col
            popc_csa_cell #(.CW(CW), .K(k)) cell_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .v_in   (v_w[k]),
                .s_in   (s_w[k]),
                .c_in   (c_w[k]),
                .bit_in (tap[k]),
                .v_q    (v_w[k+1]),
                .s_q    (s_w[k+1]),
                .c_q    (c_w[k+1])
            );
        end
    endgenerate

    popc_resolve #(.CW(CW), .LVLS(LVLS)) resolve_i (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (v_w[N]),
        .s_in  (s_w[N]),
        .c_in  (c_w[N]),
        .v_out (out_valid),
        .sum   (out_count)
    );

    logic rst_seen_q;

    // Purpose: remember that the previous edge sampled reset, for the check below.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R6: the edge after a sampled reset leaves no valid result.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clears_R6: assert (!out_valid);
        end
    end

    // R4: a valid count never exceeds the word width.
    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count <= CW'(N)));

endmodule

// File: tb/popc_systolic_tb_top.sv
`timescale 1ns/1ps
module popc_systolic_tb_top;

    localparam int N   = 8;
    localparam int CW  = $clog2(N + 1);
    localparam int LAT = N + $clog2(CW) + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_data = '0;
    logic          out_valid;
    logic [CW-1:0] out_count;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;

    logic          pv [0:LAT-1];
    logic [CW-1:0] pc [0:LAT-1];

    always #4 clk = ~clk;

    popc_systolic #(.N(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_count (out_count)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // One cycle: drive, take the edge, advance the reference delay line, compare at negedge.
    task automatic step(input logic r, input logic v, input logic [N-1:0] d, input string tag);
        rst_n    = r;
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        edges++;
        if (!r) begin
            for (int i = 0; i < LAT; i++) pv[i] = 1'b0;
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                pv[i] = pv[i-1];
                pc[i] = pc[i-1];
            end
            pv[0] = v;
            pc[0] = CW'($countones(d));
        end
        @(negedge clk);
        checks++;
        if (out_valid !== pv[LAT-1]) begin
            fails++;
            $display("FAIL %s out_valid: actual %0b expected %0b", tag, out_valid, pv[LAT-1]);
        end
        if (pv[LAT-1] === 1'b1) begin
            checks++;
            if (out_count !== pc[LAT-1]) begin
                fails++;
                $display("FAIL R1 out_count: actual %0d expected %0d", out_count, pc[LAT-1]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < LAT; i++) begin
            pv[i] = 1'b0;
            pc[i] = '0;
        end
        // R6: reset state
        repeat (3) step(1'b0, 1'b0, '0, "R6");
        // R1, R2, R4: every word back to back, includes all-zeros and all-ones
        for (int w = 0; w < (1 << N); w++) step(1'b1, 1'b1, N'(w), "R2");
        // R5: idle cycles with busy data must produce nothing
        for (int i = 0; i < LAT + 2; i++) step(1'b1, 1'b0, N'(8'hA5 ^ i), "R5");
        // R2, R5: gapped stream
        for (int i = 0; i < 64; i++) step(1'b1, i[0] | i[2], N'(i * 37), "R5");
        for (int i = 0; i < LAT + 2; i++) step(1'b1, 1'b0, '1, "R5");
        // R3: isolated all-ones word; measure when it emerges
        begin
            int start;
            int seen;
            seen  = -1;
            start = edges;
            step(1'b1, 1'b1, '1, "R3");
            for (int i = 0; i < LAT + 3; i++) begin
                if (out_valid === 1'b1 && seen < 0) seen = edges - start;
                step(1'b1, 1'b0, '0, "R3");
            end
            checks++;
            if (seen != LAT) begin
                fails++;
                $display("FAIL R3 latency: actual %0d expected %0d", seen, LAT);
            end
        end
        // R6: reset while words are in flight; none may appear afterwards
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, N'(i + 3), "R6");
        step(1'b0, 1'b1, '1, "R6");
        for (int i = 0; i < LAT + 2; i++) step(1'b1, 1'b0, '1, "R6");
        // R2: resume after reset
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, N'(255 - i * 11), "R2");
        for (int i = 0; i < LAT + 1; i++) step(1'b1, 1'b0, '0, "R5");
        summary();
    end

endmodule